// File: doc/BRIEF.md
# Dual-Pattern Overlapping Serial Sequence Detector

This block watches a serial bit stream that arrives one bit per clock on `x`. It raises a flag whenever the bits received since the last reset end in either `010` or `1001`. Matches may overlap, and a match does not clear the detector's memory. For example, the stream `0101001` gives hits on its third, fifth and seventh bits.

Two finite-state machines are fed from the same input and run side by side:

- A six-state Mealy machine. Its flag depends on the current state and the current bit, so it rises in the same cycle as the bit that completes a pattern.
- An eight-state Moore machine. Its flag is decoded from the state alone, so it rises in the cycle after the completing bit.

Both current-state codes are brought out for debug and for observation by a test environment. Reset is synchronous and active high.

Top module: `seqdet_dual`

## Requirements
- R1: While `rst` is high at a rising clock edge, both state outputs read 0 after that edge. Both `z_mealy` and `z_moore` are 0 for as long as `rst` is high, even when the current state and `x` would otherwise flag a match.
- R2: `z_mealy` is 1 in the cycle whose `x` completes the pattern 0,1,0, with the bits counted since reset. After that edge the Mealy state code is 3 ("ends in 10").
- R3: `z_mealy` is 1 in the cycle whose `x` completes the pattern 1,0,0,1. After that edge the Mealy state code is 2 ("ends in 01").
- R4: Matches overlap and a hit does not clear history. The stream 0101001 flags on bits 3, 5 and 7. The stream 1001001 flags on bits 4, 5 and 7.
- R5: `z_mealy` is 0 in every cycle in which the history since reset ends in neither 010 nor 1001. This holds for arbitrary bit streams.
- R6: `z_moore` equals the value `z_mealy` had in the previous cycle, whenever that previous cycle was not in reset.
- R7: State codes are binary.
  - Mealy codes, 0 to 5:
    - 0: reset
    - 1: ends in 0 but not 10
    - 2: ends in 01
    - 3: ends in 10
    - 4: ends in 1 but not 01
    - 5: ends in 100
  - Moore codes are 0 to 7. Only codes 4 and 7 drive a 1.
  - For the stream 0101001, the Mealy codes after each edge are 1,2,3,2,3,5,2 and the Moore codes are 1,2,4,2,4,6,7.
  - The Mealy code never exceeds 5.
- R8: Reset discards history. The bits 1,0, then a reset, then the bits 0,1 give no hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit, one per clock |
| z_mealy | output | 1 | Match flag, same cycle as the completing bit |
| z_moore | output | 1 | Match flag, one cycle after the completing bit |
| mealy_state | output | MEALY_W | Current Mealy state code |
| moore_state | output | MOORE_W | Current Moore state code |

## Verification
`z_mealy` is combinational from the registered state and the present `x`. It is therefore due in the same cycle as the bit that completes a pattern. The bench drives `x` on the falling edge and samples `z_mealy` a quarter period later, before the next rising edge registers the bit.

`z_moore` and both state codes pass through one state register. They are due one edge later, so the bench compares `z_moore` against the expectation it held for `z_mealy` in the previous cycle, and reads the state codes just after the rising edge.

The reference is a four-bit history with a count of bits received since reset, so short histories right after reset never match.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

   localparam int unsigned MEALY_COUNT = 6;
   localparam int unsigned MOORE_COUNT = 8;
   localparam int unsigned MEALY_BITS  = $clog2(MEALY_COUNT);
   localparam int unsigned MOORE_BITS  = $clog2(MOORE_COUNT);

   // Mealy states, named by what the recent history ends in
   typedef enum logic [MEALY_BITS-1:0] {
      ME_RESET = MEALY_BITS'(0),  // nothing seen yet
      ME_ZERO  = MEALY_BITS'(1),  // ...0, not ...10
      ME_ZO    = MEALY_BITS'(2),  // ...01
      ME_OZ    = MEALY_BITS'(3),  // ...10
      ME_ONE   = MEALY_BITS'(4),  // ...1, not ...01
      ME_OZZ   = MEALY_BITS'(5)   // ...100
   } mealy_st_e;

   // Moore states; codes 4 and 7 carry the match flag
   typedef enum logic [MOORE_BITS-1:0] {
      MO_RESET   = MOORE_BITS'(0),
      MO_ZERO    = MOORE_BITS'(1),
      MO_ZO      = MOORE_BITS'(2),
      MO_ONE     = MOORE_BITS'(3),
      MO_HIT_ZOZ = MOORE_BITS'(4),
      MO_OZ      = MOORE_BITS'(5),
      MO_OZZ     = MOORE_BITS'(6),
      MO_HIT_LNG = MOORE_BITS'(7)
   } moore_st_e;

endpackage

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg #(
   parameter type    state_t     = logic [2:0],
   parameter state_t RESET_STATE = state_t'(0)
) (
   input  logic   clk,
   input  logic   rst,
   input  state_t d,
   output state_t q
);

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_STATE;
      else     q <= d;
   end

endmodule

// File: rtl/seqdet_mealy.sv
module seqdet_mealy
   import seqdet_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      x,
   output mealy_st_e cur,
   output logic      z
);

   mealy_st_e nxt;
   logic      hit;

   always_comb begin
      nxt = ME_RESET;
      hit = 1'b0;
      case (cur)
         ME_RESET: nxt = x ? ME_ONE : ME_ZERO;
         ME_ZERO:  nxt = x ? ME_ZO  : ME_ZERO;
         ME_ZO: begin
            nxt = x ? ME_ONE : ME_OZ;
            hit = ~x;                 // 0,1 then 0
         end
         ME_OZ:    nxt = x ? ME_ZO  : ME_OZZ;
         ME_ONE:   nxt = x ? ME_ONE : ME_OZ;
         ME_OZZ: begin
            nxt = x ? ME_ZO : ME_ZERO;
            hit = x;                  // 1,0,0 then 1
         end
         default:  nxt = ME_RESET;    // unused codes recover
      endcase
   end

   seqdet_state_reg #(
      .state_t     (mealy_st_e),
      .RESET_STATE (ME_RESET)
   ) st_reg_i (
      .clk (clk),
      .rst (rst),
      .d   (nxt),
      .q   (cur)
   );

   assign z = hit & ~rst;

endmodule

// File: rtl/seqdet_moore.sv
module seqdet_moore
   import seqdet_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      x,
   output moore_st_e cur,
   output logic      z
);

   moore_st_e nxt;

   always_comb begin
      nxt = MO_RESET;
      case (cur)
         MO_RESET:   nxt = x ? MO_ONE     : MO_ZERO;
         MO_ZERO:    nxt = x ? MO_ZO      : MO_ZERO;
         MO_ZO:      nxt = x ? MO_ONE     : MO_HIT_ZOZ;
         MO_ONE:     nxt = x ? MO_ONE     : MO_OZ;
         MO_HIT_ZOZ: nxt = x ? MO_ZO      : MO_OZZ;
         MO_OZ:      nxt = x ? MO_ZO      : MO_OZZ;
         MO_OZZ:     nxt = x ? MO_HIT_LNG : MO_ZERO;
         MO_HIT_LNG: nxt = x ? MO_ONE     : MO_HIT_ZOZ;
         default:    nxt = MO_RESET;
      endcase
   end

   seqdet_state_reg #(
      .state_t     (moore_st_e),
      .RESET_STATE (MO_RESET)
   ) st_reg_i (
      .clk (clk),
      .rst (rst),
      .d   (nxt),
      .q   (cur)
   );

   assign z = ~rst & ((cur == MO_HIT_ZOZ) | (cur == MO_HIT_LNG));

endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
   import seqdet_pkg::*;
#(
   parameter int unsigned MEALY_W = seqdet_pkg::MEALY_BITS,
   parameter int unsigned MOORE_W = seqdet_pkg::MOORE_BITS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               x,
   output logic               z_mealy,
   output logic               z_moore,
   output logic [MEALY_W-1:0] mealy_state,
   output logic [MOORE_W-1:0] moore_state
);

   localparam int unsigned ME_PAD = MEALY_W - MEALY_BITS;
   localparam int unsigned MO_PAD = MOORE_W - MOORE_BITS;

   generate
      if (MEALY_W < MEALY_BITS) begin : g_bad_mealy_w
         $error("seqdet_dual: MEALY_W too narrow for the Mealy state code");
      end
      if (MOORE_W < MOORE_BITS) begin : g_bad_moore_w
         $error("seqdet_dual: MOORE_W too narrow for the Moore state code");
      end
   endgenerate

   mealy_st_e me_cur;
   moore_st_e mo_cur;

   seqdet_mealy mealy_i (
      .clk (clk),
      .rst (rst),
      .x   (x),
      .cur (me_cur),
      .z   (z_mealy)
   );

   seqdet_moore moore_i (
      .clk (clk),
      .rst (rst),
      .x   (x),
      .cur (mo_cur),
      .z   (z_moore)
   );

   generate
      if (ME_PAD == 0) begin : g_me_exact
         assign mealy_state = me_cur;
      end else begin : g_me_pad
         assign mealy_state = {{ME_PAD{1'b0}}, me_cur};
      end
      if (MO_PAD == 0) begin : g_mo_exact
         assign moore_state = mo_cur;
      end else begin : g_mo_pad
         assign moore_state = {{MO_PAD{1'b0}}, mo_cur};
      end
   endgenerate

endmodule

// File: rtl/seqdet_dual_chk.sv
module seqdet_dual_chk #(
   parameter int unsigned MEALY_W = 3,
   parameter int unsigned MOORE_W = 3
) (
   input logic               clk,
   input logic               rst,
   input logic               x,
   input logic               z_mealy,
   input logic               z_moore,
   input logic [MEALY_W-1:0] mealy_state,
   input logic [MOORE_W-1:0] moore_state
);

   // high once the previous cycle ran outside reset
   logic live;
   always_ff @(posedge clk) begin
      if (rst) live <= 1'b0;
      else     live <= 1'b1;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (mealy_state == '0) && (moore_state == '0));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |-> (!z_mealy && !z_moore));

   // R2
   hit_short_next_chk: assert property (@(posedge clk) disable iff (rst)
      (z_mealy && !x) |=> (mealy_state == MEALY_W'(3)) && (moore_state == MOORE_W'(4)));

   // R3
   hit_long_next_chk: assert property (@(posedge clk) disable iff (rst)
      (z_mealy && x) |=> (mealy_state == MEALY_W'(2)) && (moore_state == MOORE_W'(7)));

   // R6
   moore_lag_chk: assert property (@(posedge clk) disable iff (rst)
      live |-> (z_moore == $past(z_mealy)));

   // R7
   mealy_code_range_chk: assert property (@(posedge clk) disable iff (rst)
      live |-> (mealy_state <= MEALY_W'(5)));

endmodule

bind seqdet_dual seqdet_dual_chk #(
   .MEALY_W (MEALY_W),
   .MOORE_W (MOORE_W)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .x           (x),
   .z_mealy     (z_mealy),
   .z_moore     (z_moore),
   .mealy_state (mealy_state),
   .moore_state (moore_state)
);

// File: tb/seqdet_dual_tb_top.sv
module seqdet_dual_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       x   = 1'b0;
   logic       z_mealy, z_moore;
   logic [2:0] mealy_state, moore_state;

   int         n_chk  = 0;
   int         n_fail = 0;
   int         nbits  = 0;
   logic [3:0] hist   = 4'b0;
   logic       prev_exp = 1'b0;
   logic       hit;

   always #10 clk = ~clk;   // 50 MHz

   seqdet_dual dut_i (
      .clk         (clk),
      .rst         (rst),
      .x           (x),
      .z_mealy     (z_mealy),
      .z_moore     (z_moore),
      .mealy_state (mealy_state),
      .moore_state (moore_state)
   );

   function automatic logic ref_hit(input logic b);
      logic [3:0] h;
      h = {hist[2:0], b};
      return ((nbits + 1 >= 3) && (h[2:0] == 3'b010)) ||
             ((nbits + 1 >= 4) && (h == 4'b1001));
   endfunction

   task automatic chk1(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic chk3(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one bit: drive on falling edge, check flags before the rising edge
   task automatic step(input logic b, input string req_me, input string req_mo, output logic h);
      @(negedge clk);
      rst = 1'b0;
      x   = b;
      #5;
      h = ref_hit(b);
      chk1(req_me, "z_mealy", z_mealy, h);
      chk1(req_mo, "z_moore", z_moore, prev_exp);
      @(posedge clk);
      hist     = {hist[2:0], b};
      nbits    = nbits + 1;
      prev_exp = h;
   endtask

   // hold reset for one edge; rst stays high until the next step
   task automatic do_reset(input logic xb);
      @(negedge clk);
      rst = 1'b1;
      x   = xb;
      #5;
      chk1("R1", "z_mealy in reset", z_mealy, 1'b0);
      chk1("R1", "z_moore in reset", z_moore, 1'b0);
      @(posedge clk);
      #2;
      chk3("R1", "mealy_state after reset", mealy_state, 3'd0);
      chk3("R1", "moore_state after reset", moore_state, 3'd0);
      nbits    = 0;
      hist     = 4'b0;
      prev_exp = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      do_reset(1'b0);

      // R2: 0,1,0 from reset
      step(1'b0, "R2", "R6", hit);
      step(1'b1, "R2", "R6", hit);
      step(1'b0, "R2", "R6", hit);
      chk1("R2", "reference hit on 010", hit, 1'b1);
      #2 chk3("R2", "mealy_state after 010", mealy_state, 3'd3);
      step(1'b1, "R2", "R6", hit);   // z_moore due here

      // R1: reset while Mealy would flag (state ends in 01, x=0)
      do_reset(1'b0);
      step(1'b0, "R1", "R6", hit);
      step(1'b1, "R1", "R6", hit);
      do_reset(1'b0);

      // R3: 1,0,0,1
      step(1'b1, "R3", "R6", hit);
      step(1'b0, "R3", "R6", hit);
      step(1'b0, "R3", "R6", hit);
      step(1'b1, "R3", "R6", hit);
      chk1("R3", "reference hit on 1001", hit, 1'b1);
      #2 chk3("R3", "mealy_state after 1001", mealy_state, 3'd2);
      step(1'b0, "R3", "R6", hit);

      // R4 / R7: 0101001 with state codes after each edge
      begin
         logic [6:0] seq_a = 7'b0101001;
         int me_exp [7] = '{1, 2, 3, 2, 3, 5, 2};
         int mo_exp [7] = '{1, 2, 4, 2, 4, 6, 7};
         do_reset(1'b0);
         for (int i = 0; i < 7; i++) begin
            step(seq_a[6-i], "R4", "R6", hit);
            #2;
            chk3("R7", "mealy_state", mealy_state, 3'(me_exp[i]));
            chk3("R7", "moore_state", moore_state, 3'(mo_exp[i]));
         end
         step(1'b1, "R4", "R6", hit);
      end

      // R4: 1001001, hits at bits 4, 5 and 7
      begin
         logic [6:0] seq_b = 7'b1001001;
         do_reset(1'b0);
         for (int i = 0; i < 7; i++) begin
            step(seq_b[6-i], "R4", "R6", hit);
            if (i == 3 || i == 4 || i == 6) chk1("R4", "reference overlap hit", hit, 1'b1);
         end
         step(1'b0, "R4", "R6", hit);
      end

      // R8: 1,0 | reset | 0,1 must not flag
      do_reset(1'b0);
      step(1'b1, "R8", "R6", hit);
      step(1'b0, "R8", "R6", hit);
      do_reset(1'b0);
      step(1'b0, "R8", "R6", hit);
      step(1'b1, "R8", "R6", hit);
      #2 chk1("R8", "z_mealy after reset split", z_mealy, 1'b0);
      step(1'b0, "R8", "R6", hit);   // ends 010 after reset: a true hit

      // R5 / R6: random streams with occasional resets
      for (int k = 0; k < 3000; k++) begin
         if (($urandom % 250) == 0) do_reset(1'($urandom));
         step(1'($urandom), "R5", "R6", hit);
      end

      // R5: runs of ones and zeros never flag
      do_reset(1'b0);
      for (int k = 0; k < 6; k++) step(1'b1, "R5", "R6", hit);
      for (int k = 0; k < 2; k++) step(1'b0, "R5", "R6", hit);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule